// File: doc/BRIEF.md
# Paging MMU Control and Command Sequencer

This block is the software-facing control plane of a two-level paging translation unit. Software reaches it through a narrow 32-bit register port with combinational read-back. It holds the translation directory base, the fault-reporting state and the interrupt registers. Numbered commands written to one register move the block between its operating states. The translation datapath sits alongside the block. The block drives that datapath's paging enable, its stall request, and its whole-cache and single-line invalidate pulses. It receives the datapath's page-fault and bus-error events and its stall acknowledge.

Command sequencing is a four-state machine:
- `ST_RUN` is normal operation, with paging either on or off.
- `ST_STALL_WAIT` means a stall has been requested and the datapath has not yet acknowledged it.
- `ST_STALLED` means the datapath is quiesced.
- `ST_RESET` is a forced-reset window of `RST_CYC` cycles.

The transitions are:
- `RUN→STALL_WAIT` on a stall-on command while paging is enabled.
- `STALL_WAIT→STALLED` on the acknowledge.
- `STALL_WAIT/STALLED→RUN` on a stall-off command.
- `any→RESET` on a forced-reset command.
- `RESET→RUN` when the window counter expires.

Paging enable is a separate flag, so paging can be switched off while the datapath is stalled.

Top module: `mmu_ctl_seq`

## Requirements
- R1: After reset, the status word (offset 0x04) reads 0x8000_0018 when the datapath reports idle and replay-empty. The directory (0x00), interrupt mask (0x1C), raw interrupts (0x14) and fault address (0x0C) read zero, and `pg_en_o`, `stall_req_o` and `irq_o` are low.
- R2: The directory base register (0x00) stores only bits 31:12, and bits 11:0 always read as zero. Writing 0xCAFEBABE reads back 0xCAFEB000, and the same value appears on `dir_base_o`.
- R3: Writing command 0 to the command register (0x08) turns paging on, and command 1 turns it off. Status bit 0 and `pg_en_o` follow on the cycle after the write.
- R4: Command 2 raises `stall_req_o` only while paging is enabled; otherwise it has no effect. Status bit 2 (stall active) is set only after `stall_ack_i`, and status bit 31 reads the inverse of bit 2.
- R5: Command 3 withdraws the stall request and clears status bit 2. Paging keeps its previous enable state.
- R6: A fault event sets raw interrupt bit 0 and a bus-error event sets raw bit 1. The masked status at 0x20 equals raw AND mask, and `irq_o` is the OR of the masked bits.
- R7: Writing ones to the clear register (0x18) clears exactly the matching raw bits. No command clears raw bits.
- R8: The first fault sets status bit 1 and captures the fault address at 0x0C and the write flag at status bit 5. Further faults leave both unchanged. Command 5 clears status bit 1 and re-arms the capture.
- R9: Command 4 produces a single-cycle `inval_all_o` pulse. A write to 0x10 produces a single-cycle `inval_line_o` pulse with the written value on `inval_addr_o`.
- R10: Command 6 returns every register to its reset value and drops paging and stall. For `RST_CYC` cycles, status bit 3 (idle) reads 0 and register writes are ignored. After that window, normal operation resumes.
- R11: Bit 0 of the register at 0x24 is read/write and drives `gate_en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Combinational read data for `reg_addr_i` |
| pg_en_o | output | 1 | Paging enable to the datapath |
| stall_req_o | output | 1 | Stall request to the datapath |
| stall_ack_i | input | 1 | Datapath quiesced |
| inval_all_o | output | 1 | Whole-cache invalidate pulse |
| inval_line_o | output | 1 | Single-line invalidate pulse |
| inval_addr_o | output | 32 | Address for the single-line invalidate |
| gate_en_o | output | 1 | Automatic clock-gating enable |
| dir_base_o | output | 32 | Directory base to the page walker |
| fault_evt_i | input | 1 | Page-fault event, one cycle |
| fault_addr_i | input | 32 | Faulting virtual address |
| fault_wr_i | input | 1 | Faulting access was a write |
| berr_evt_i | input | 1 | Bus read error event, one cycle |
| dp_idle_i | input | 1 | Datapath idle |
| replay_empty_i | input | 1 | Replay buffer empty |
| irq_o | output | 1 | Interrupt request |

## Verification
The stall command is first issued with paging off and then with paging on, which separates a gated request from an unconditional one. The acknowledge is held back for a cycle so that the requested state can be told apart from the stalled state. Interrupt tests inject a fault with the mask closed and then a bus error with only its bit unmasked. This shows that masking works per bit and that a selective clear leaves the other raw bit set. A second fault with a different address and direction shows that capture holds until the fault-done command, and a fault after re-arming shows that capture resumes. The forced reset is issued with every register non-zero. A write is attempted inside the reset window, and completion is detected by polling the idle bit.

// File: rtl/mmu_ctl_pkg.sv
package mmu_ctl_pkg;

    typedef enum logic [1:0] {
        ST_RUN        = 2'd0,
        ST_STALL_WAIT = 2'd1,
        ST_STALLED    = 2'd2,
        ST_RESET      = 2'd3
    } seq_state_t;

    localparam int unsigned DW = 32;

    // Register offsets, decoded by software.
    localparam logic [7:0] OFS_DIR   = 8'h00;
    localparam logic [7:0] OFS_STAT  = 8'h04;
    localparam logic [7:0] OFS_CMD   = 8'h08;
    localparam logic [7:0] OFS_FADDR = 8'h0C;
    localparam logic [7:0] OFS_LINE  = 8'h10;
    localparam logic [7:0] OFS_RAW   = 8'h14;
    localparam logic [7:0] OFS_CLR   = 8'h18;
    localparam logic [7:0] OFS_MASK  = 8'h1C;
    localparam logic [7:0] OFS_MSKD  = 8'h20;
    localparam logic [7:0] OFS_GATE  = 8'h24;

    // Command codes.
    localparam logic [DW-1:0] CMD_PG_ON    = 32'd0;
    localparam logic [DW-1:0] CMD_PG_OFF   = 32'd1;
    localparam logic [DW-1:0] CMD_STALL_ON = 32'd2;
    localparam logic [DW-1:0] CMD_STALL_OF = 32'd3;
    localparam logic [DW-1:0] CMD_INV_ALL  = 32'd4;
    localparam logic [DW-1:0] CMD_PF_DONE  = 32'd5;
    localparam logic [DW-1:0] CMD_RESET    = 32'd6;

    localparam int unsigned IRQ_N = 2;

endpackage

// File: rtl/mmu_stall_fsm.sv
module mmu_stall_fsm
    import mmu_ctl_pkg::*;
#(
    parameter int unsigned RST_CYC = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_vld,
    input  logic [DW-1:0] cmd_code,
    input  logic          stall_ack,
    output seq_state_t    state,
    output logic          pg_en,
    output logic          stall_req,
    output logic          stall_act,
    output logic          soft_clr,
    output logic          inval_all,
    output logic          pf_done
);
    localparam int unsigned CW = $clog2(RST_CYC + 1);

    seq_state_t    state_q, state_nx;
    logic [CW-1:0] rcnt_q;
    logic          pg_q;
    logic          inval_q;
    logic          go_reset;

    assign go_reset = cmd_vld && (cmd_code == CMD_RESET);

    // State register and the flags the commands set.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            rcnt_q  <= '0;
            pg_q    <= 1'b0;
            inval_q <= 1'b0;
        end else begin
            state_q <= state_nx;
            rcnt_q  <= (state_q == ST_RESET) ? rcnt_q + 1'b1 : '0;
            inval_q <= cmd_vld && (cmd_code == CMD_INV_ALL);
            if (go_reset || state_q == ST_RESET)
                pg_q <= 1'b0;
            else if (cmd_vld && cmd_code == CMD_PG_ON)
                pg_q <= 1'b1;
            else if (cmd_vld && cmd_code == CMD_PG_OFF)
                pg_q <= 1'b0;
        end
    end

    // Next-state logic.
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (go_reset)
                    state_nx = ST_RESET;
                else if (cmd_vld && cmd_code == CMD_STALL_ON && pg_q)
                    state_nx = ST_STALL_WAIT;
            end
            ST_STALL_WAIT: begin
                if (go_reset)
                    state_nx = ST_RESET;
                else if (cmd_vld && cmd_code == CMD_STALL_OF)
                    state_nx = ST_RUN;
                else if (stall_ack)
                    state_nx = ST_STALLED;
            end
            ST_STALLED: begin
                if (go_reset)
                    state_nx = ST_RESET;
                else if (cmd_vld && cmd_code == CMD_STALL_OF)
                    state_nx = ST_RUN;
            end
            ST_RESET: begin
                if (rcnt_q == CW'(RST_CYC - 1))
                    state_nx = ST_RUN;
            end
        endcase
    end

    // Outputs.
    always_comb begin
        state     = state_q;
        pg_en     = pg_q;
        stall_req = (state_q == ST_STALL_WAIT) || (state_q == ST_STALLED);
        stall_act = (state_q == ST_STALLED);
        soft_clr  = (state_q == ST_RESET);
        inval_all = inval_q;
        pf_done   = cmd_vld && (cmd_code == CMD_PF_DONE);
    end
endmodule

// File: rtl/mmu_irq_unit.sv
module mmu_irq_unit
    import mmu_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_clr,
    input  logic             flt_evt,
    input  logic [DW-1:0]    flt_addr,
    input  logic             flt_wr,
    input  logic             berr_evt,
    input  logic             clr_vld,
    input  logic             msk_vld,
    input  logic [IRQ_N-1:0] wbits,
    input  logic             pf_done,
    output logic [IRQ_N-1:0] raw,
    output logic [IRQ_N-1:0] mask,
    output logic [IRQ_N-1:0] masked,
    output logic             fact,
    output logic [DW-1:0]    faddr,
    output logic             fwr,
    output logic             irq
);
    logic [IRQ_N-1:0] raw_q, msk_q, clr_m, set_m;
    logic             fact_q, fwr_q;
    logic [DW-1:0]    faddr_q;

    assign clr_m = clr_vld ? wbits : '0;
    assign set_m = {berr_evt, flt_evt};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q   <= '0;
            msk_q   <= '0;
            fact_q  <= 1'b0;
            fwr_q   <= 1'b0;
            faddr_q <= '0;
        end else if (soft_clr) begin
            raw_q   <= '0;
            msk_q   <= '0;
            fact_q  <= 1'b0;
            fwr_q   <= 1'b0;
            faddr_q <= '0;
        end else begin
            raw_q <= (raw_q & ~clr_m) | set_m;
            if (msk_vld)
                msk_q <= wbits;
            if (flt_evt && !fact_q) begin
                fact_q  <= 1'b1;
                faddr_q <= flt_addr;
                fwr_q   <= flt_wr;
            end else if (pf_done) begin
                fact_q <= 1'b0;
            end
        end
    end

    assign raw    = raw_q;
    assign mask   = msk_q;
    assign masked = raw_q & msk_q;
    assign irq    = |(raw_q & msk_q);
    assign fact   = fact_q;
    assign faddr  = faddr_q;
    assign fwr    = fwr_q;
endmodule

// File: rtl/mmu_ctl_seq.sv
module mmu_ctl_seq
    import mmu_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned PAGE_SHIFT = 12,
    parameter int unsigned RST_CYC    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    output logic              pg_en_o,
    output logic              stall_req_o,
    input  logic              stall_ack_i,
    output logic              inval_all_o,
    output logic              inval_line_o,
    output logic [31:0]       inval_addr_o,
    output logic              gate_en_o,
    output logic [31:0]       dir_base_o,
    input  logic              fault_evt_i,
    input  logic [31:0]       fault_addr_i,
    input  logic              fault_wr_i,
    input  logic              berr_evt_i,
    input  logic              dp_idle_i,
    input  logic              replay_empty_i,
    output logic              irq_o
);
    localparam logic [DW-1:0] DIR_KEEP = {{(DW-PAGE_SHIFT){1'b1}}, {PAGE_SHIFT{1'b0}}};

    seq_state_t       state;
    logic             wr_ok, soft_clr, stall_act, pf_done;
    logic             fact, fwr;
    logic [DW-1:0]    faddr;
    logic [IRQ_N-1:0] raw, mask, masked;
    logic [DW-1:0]    dir_q, laddr_q;
    logic             line_q, gate_q;
    logic [DW-1:0]    stat_w;

    assign wr_ok = reg_wr_i && !soft_clr;

    mmu_stall_fsm #(.RST_CYC(RST_CYC)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_vld   (wr_ok && reg_addr_i == ADDR_W'(OFS_CMD)),
        .cmd_code  (reg_wdata_i),
        .stall_ack (stall_ack_i),
        .state     (state),
        .pg_en     (pg_en_o),
        .stall_req (stall_req_o),
        .stall_act (stall_act),
        .soft_clr  (soft_clr),
        .inval_all (inval_all_o),
        .pf_done   (pf_done)
    );

    mmu_irq_unit u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_clr),
        .flt_evt  (fault_evt_i),
        .flt_addr (fault_addr_i),
        .flt_wr   (fault_wr_i),
        .berr_evt (berr_evt_i),
        .clr_vld  (wr_ok && reg_addr_i == ADDR_W'(OFS_CLR)),
        .msk_vld  (wr_ok && reg_addr_i == ADDR_W'(OFS_MASK)),
        .wbits    (reg_wdata_i[IRQ_N-1:0]),
        .pf_done  (pf_done),
        .raw      (raw),
        .mask     (mask),
        .masked   (masked),
        .fact     (fact),
        .faddr    (faddr),
        .fwr      (fwr),
        .irq      (irq_o)
    );

    // Plain storage registers and the line-invalidate pulse.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q   <= '0;
            gate_q  <= 1'b0;
            line_q  <= 1'b0;
            laddr_q <= '0;
        end else if (soft_clr) begin
            dir_q   <= '0;
            gate_q  <= 1'b0;
            line_q  <= 1'b0;
            laddr_q <= '0;
        end else begin
            if (wr_ok && reg_addr_i == ADDR_W'(OFS_DIR))
                dir_q <= reg_wdata_i & DIR_KEEP;
            if (wr_ok && reg_addr_i == ADDR_W'(OFS_GATE))
                gate_q <= reg_wdata_i[0];
            line_q <= wr_ok && reg_addr_i == ADDR_W'(OFS_LINE);
            if (wr_ok && reg_addr_i == ADDR_W'(OFS_LINE))
                laddr_q <= reg_wdata_i;
        end
    end

    assign stat_w = {~stall_act, 25'd0, fwr, replay_empty_i,
                     dp_idle_i && !soft_clr, stall_act, fact, pg_en_o};

    always_comb begin
        reg_rdata_o = '0;
        unique case (reg_addr_i)
            ADDR_W'(OFS_DIR):   reg_rdata_o = dir_q;
            ADDR_W'(OFS_STAT):  reg_rdata_o = stat_w;
            ADDR_W'(OFS_FADDR): reg_rdata_o = faddr;
            ADDR_W'(OFS_RAW):   reg_rdata_o = DW'(raw);
            ADDR_W'(OFS_MASK):  reg_rdata_o = DW'(mask);
            ADDR_W'(OFS_MSKD):  reg_rdata_o = DW'(masked);
            ADDR_W'(OFS_GATE):  reg_rdata_o = DW'(gate_q);
            default:            reg_rdata_o = '0;
        endcase
    end

    assign inval_line_o = line_q;
    assign inval_addr_o = laddr_q;
    assign gate_en_o    = gate_q;
    assign dir_base_o   = dir_q;
endmodule

// File: rtl/mmu_ctl_chk.sv
module mmu_ctl_chk
    import mmu_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic              reg_wr_i,
    input logic [31:0]       reg_wdata_i,
    input logic [31:0]       reg_rdata_o,
    input logic              pg_en_o,
    input logic              stall_req_o,
    input logic              inval_all_o,
    input logic              irq_o,
    input logic              soft_clr,
    input logic              fact,
    input logic [31:0]       faddr
);
    logic cmd_wr;
    assign cmd_wr = reg_wr_i && !soft_clr && reg_addr_i == ADDR_W'(OFS_CMD);

    AST_DIR_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i == ADDR_W'(OFS_DIR)) |-> (reg_rdata_o[11:0] == 12'd0)); // R2

    AST_STALL_NEEDS_PAGING: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall_req_o) |-> $past(pg_en_o)); // R4

    AST_STALL_DROP_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall_req_o) |-> $past(cmd_wr && (reg_wdata_i == CMD_STALL_OF || reg_wdata_i == CMD_RESET))); // R5

    AST_MASK_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && !soft_clr && reg_addr_i == ADDR_W'(OFS_MASK) && reg_wdata_i[1:0] == 2'b00) |=> !irq_o); // R6

    AST_FAULT_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (fact && $past(fact)) |-> $stable(faddr)); // R8

    AST_INVAL_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        inval_all_o |-> $past(cmd_wr && reg_wdata_i == CMD_INV_ALL)); // R9

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |-> (!pg_en_o && !stall_req_o)); // R10
endmodule

bind mmu_ctl_seq mmu_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_addr_i  (reg_addr_i),
    .reg_wr_i    (reg_wr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .pg_en_o     (pg_en_o),
    .stall_req_o (stall_req_o),
    .inval_all_o (inval_all_o),
    .irq_o       (irq_o),
    .soft_clr    (soft_clr),
    .fact        (fact),
    .faddr       (faddr)
);

// File: tb/tb_mmu_ctl_seq.sv
module tb_mmu_ctl_seq;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr_i = '0;
    logic        reg_wr_i = 1'b0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic        pg_en_o, stall_req_o, inval_all_o, inval_line_o, gate_en_o, irq_o;
    logic [31:0] inval_addr_o, dir_base_o;
    logic        stall_ack_i = 1'b0;
    logic        fault_evt_i = 1'b0;
    logic [31:0] fault_addr_i = '0;
    logic        fault_wr_i = 1'b0;
    logic        berr_evt_i = 1'b0;
    logic        dp_idle_i = 1'b1;
    logic        replay_empty_i = 1'b1;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    mmu_ctl_seq dut (
        .clk(clk), .rst_n(rst_n), .reg_addr_i(reg_addr_i), .reg_wr_i(reg_wr_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .pg_en_o(pg_en_o),
        .stall_req_o(stall_req_o), .stall_ack_i(stall_ack_i), .inval_all_o(inval_all_o),
        .inval_line_o(inval_line_o), .inval_addr_o(inval_addr_o), .gate_en_o(gate_en_o),
        .dir_base_o(dir_base_o), .fault_evt_i(fault_evt_i), .fault_addr_i(fault_addr_i),
        .fault_wr_i(fault_wr_i), .berr_evt_i(berr_evt_i), .dp_idle_i(dp_idle_i),
        .replay_empty_i(replay_empty_i), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
        @(negedge clk);
        reg_wr_i = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr_i = a;
        #1;
        d = reg_rdata_o;
    endtask

    task automatic fault(input logic [31:0] a, input logic w);
        @(negedge clk);
        fault_evt_i = 1'b1; fault_addr_i = a; fault_wr_i = w;
        @(negedge clk);
        fault_evt_i = 1'b0;
    endtask

    task automatic t_reset_state;
        logic [31:0] d;
        rd(8'h04, d); check("R1 status", d, 32'h8000_0018);
        rd(8'h00, d); check("R1 dir", d, 32'h0);
        rd(8'h1C, d); check("R1 mask", d, 32'h0);
        rd(8'h14, d); check("R1 raw", d, 32'h0);
        rd(8'h0C, d); check("R1 faddr", d, 32'h0);
        check("R1 outputs", {29'd0, pg_en_o, stall_req_o, irq_o}, 32'h0);
    endtask

    task automatic t_dir;
        logic [31:0] d;
        wr(8'h00, 32'hCAFE_BABE);
        rd(8'h00, d); check("R2 dir readback", d, 32'hCAFE_B000);
        check("R2 dir_base_o", dir_base_o, 32'hCAFE_B000);
    endtask

    task automatic t_stall_and_paging;
        logic [31:0] d;
        wr(8'h08, 32'd2);
        check("R4 stall ignored without paging", {31'd0, stall_req_o}, 32'h0);
        rd(8'h04, d); check("R4 status stall bit off", {31'd0, d[2]}, 32'h0);
        wr(8'h08, 32'd0);
        check("R3 pg_en_o on", {31'd0, pg_en_o}, 32'h1);
        rd(8'h04, d); check("R3 status paging bit", {31'd0, d[0]}, 32'h1);
        wr(8'h08, 32'd2);
        check("R4 stall request raised", {31'd0, stall_req_o}, 32'h1);
        rd(8'h04, d); check("R4 not stalled before ack", {d[31], d[2]}, 32'h2);
        stall_ack_i = 1'b1;
        @(negedge clk);
        rd(8'h04, d); check("R4 stalled after ack", {d[31], d[2]}, 32'h1);
        wr(8'h08, 32'd3);
        stall_ack_i = 1'b0;
        check("R5 stall request dropped", {31'd0, stall_req_o}, 32'h0);
        rd(8'h04, d); check("R5 status after stall off", {d[31], d[2], d[0]}, 32'h5);
        check("R5 paging kept", {31'd0, pg_en_o}, 32'h1);
        wr(8'h08, 32'd1);
        check("R3 pg_en_o off", {31'd0, pg_en_o}, 32'h0);
    endtask

    task automatic t_irq_fault;
        logic [31:0] d;
        fault(32'h1234_5678, 1'b1);
        rd(8'h14, d); check("R6 raw fault bit", d, 32'h1);
        rd(8'h20, d); check("R6 masked zero", d, 32'h0);
        check("R6 irq low when masked", {31'd0, irq_o}, 32'h0);
        rd(8'h04, d); check("R8 fault active + write flag", {30'd0, d[5], d[1]}, 32'h3);
        rd(8'h0C, d); check("R8 captured address", d, 32'h1234_5678);
        fault(32'hAAAA_0000, 1'b0);
        rd(8'h0C, d); check("R8 second fault ignored", d, 32'h1234_5678);
        rd(8'h04, d); check("R8 write flag held", {31'd0, d[5]}, 32'h1);
        @(negedge clk); berr_evt_i = 1'b1;
        @(negedge clk); berr_evt_i = 1'b0;
        rd(8'h14, d); check("R6 raw both bits", d, 32'h3);
        wr(8'h1C, 32'h2);
        rd(8'h20, d); check("R6 masked bus error", d, 32'h2);
        check("R6 irq high", {31'd0, irq_o}, 32'h1);
        wr(8'h18, 32'h2);
        rd(8'h14, d); check("R7 selective clear", d, 32'h1);
        check("R7 irq low after clear", {31'd0, irq_o}, 32'h0);
        wr(8'h08, 32'd5);
        rd(8'h04, d); check("R8 fault done clears active", {31'd0, d[1]}, 32'h0);
        rd(8'h14, d); check("R7 command leaves raw", d, 32'h1);
        wr(8'h18, 32'h1);
        rd(8'h14, d); check("R7 raw cleared", d, 32'h0);
        fault(32'h0000_5000, 1'b0);
        rd(8'h0C, d); check("R8 re-armed capture", d, 32'h0000_5000);
        rd(8'h04, d); check("R8 read flag", {31'd0, d[5]}, 32'h0);
    endtask

    task automatic t_inval;
        wr(8'h08, 32'd4);
        check("R9 inval_all pulse", {31'd0, inval_all_o}, 32'h1);
        @(negedge clk);
        check("R9 inval_all single cycle", {31'd0, inval_all_o}, 32'h0);
        wr(8'h10, 32'h0040_3000);
        check("R9 inval_line pulse", {31'd0, inval_line_o}, 32'h1);
        check("R9 inval address", inval_addr_o, 32'h0040_3000);
        @(negedge clk);
        check("R9 inval_line single cycle", {31'd0, inval_line_o}, 32'h0);
    endtask

    task automatic t_gate;
        logic [31:0] d;
        wr(8'h24, 32'h1);
        check("R11 gate_en_o", {31'd0, gate_en_o}, 32'h1);
        rd(8'h24, d); check("R11 readback", d, 32'h1);
    endtask

    task automatic t_force_reset;
        logic [31:0] d;
        bit done;
        wr(8'h00, 32'hCAFE_BABE);
        wr(8'h1C, 32'h3);
        wr(8'h08, 32'd0);
        fault(32'h0000_9000, 1'b1);
        wr(8'h08, 32'd6);
        rd(8'h04, d); check("R10 idle low in reset", {31'd0, d[3]}, 32'h0);
        wr(8'h00, 32'h1111_1000);
        done = 1'b0;
        for (int i = 0; i < 64 && !done; i++) begin
            @(negedge clk);
            rd(8'h04, d);
            if (d[3]) done = 1'b1;
        end
        check("R10 reset window ends", {31'd0, done}, 32'h1);
        rd(8'h04, d); check("R10 status", d, 32'h8000_0018);
        rd(8'h00, d); check("R10 dir zero, write ignored", d, 32'h0);
        rd(8'h1C, d); check("R10 mask", d, 32'h0);
        rd(8'h14, d); check("R10 raw", d, 32'h0);
        rd(8'h0C, d); check("R10 faddr", d, 32'h0);
        check("R10 outputs", {28'd0, pg_en_o, stall_req_o, gate_en_o, irq_o}, 32'h0);
        wr(8'h00, 32'h0000_7000);
        rd(8'h00, d); check("R10 writes resume", d, 32'h0000_7000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_dir();
        t_stall_and_paging();
        t_irq_fault();
        t_inval();
        t_gate();
        t_force_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule